// File: doc/BRIEF.md
# Store-Byte Register-Offset Decoder

This block recognises one instruction, a byte store whose address offset comes from a register, and turns it into decoded fields. The instruction arrives in one of three shapes. A 16-bit compact form and a 32-bit compact form both come in on a halfword stream. The 32-bit compact form takes two consecutive halfword beats. A 32-bit conditional form comes in whole on a separate word input.

For every decoded instruction the block presents, one cycle later, the following:
- the three register indices;
- the pre-index, add and writeback flags;
- a shift type and a shift amount;
- a condition code.

It also raises three flags: undefined, unpredictable, and redirect to the unprivileged store variant. A pattern that is not this instruction still yields a valid output, with a "not this instruction" flag set. An architecture-version input selects one extra unpredictable rule that applies only to pre-v6 cores.

The block sits in a front end ahead of an execute stage. It does not perform the store and does not evaluate the condition.

Top module: `sb_regoff_decoder`

## Requirements
- R1: After a synchronous active-low reset, `dec_valid` is 0 and no halfword is held, so the next halfword beat is treated as a first halfword.
- R2: A halfword whose bits 15:9 are 0101010, arriving with nothing held, decodes as follows one cycle later:
  - rm = bits 8:6, rn = bits 5:3, rt = bits 2:0, each zero-extended to 4 bits;
  - index = 1, add = 1, writeback = 0;
  - shift type 00 (LSL), amount 0, condition 1110;
  - no error flags.
- R3: A halfword whose top five bits are 11101, 11110 or 11111, arriving with nothing held, is held and produces no output. The next halfword beat, after any number of idle cycles, completes a 32-bit instruction and is decoded one cycle later.
- R4: A 32-bit compact pair matches when the first halfword bits 15:4 are 111110000000 and the second halfword bits 11:6 are zero. It then decodes as follows:
  - rn = first halfword bits 3:0;
  - rt = second halfword bits 15:12, rm = second halfword bits 3:0;
  - shift type 00, amount = second halfword bits 5:4;
  - index = 1, add = 1, writeback = 0, condition 1110.
- R5: In the 32-bit compact form, rn = 1111 raises undefined.
- R6: In the 32-bit compact form, rt or rm equal to 13 or 15 raises unpredictable.
- R7: A word matches the conditional form when bits 27:25 = 011, bit 22 = 1, bit 20 = 0 and bit 4 = 0. It then decodes as follows:
  - cond = bits 31:28, rn = 19:16, rt = 15:12, rm = 3:0;
  - shift type = bits 6:5 and amount = bits 11:7, both passed raw;
  - index = bit 24 (P), add = bit 23 (U), writeback = !P | W, where W is bit 21.
- R8: In the conditional form without redirect, unpredictable is raised when rt = 15, rm = 15, or writeback holds with rn = 15 or rn = rt.
- R9: In the conditional form without redirect, when `arch_v6_up` is 0, writeback with rm = rn also raises unpredictable.
- R10: In the conditional form, P = 0 with W = 1 raises redirect. Undefined and unpredictable are then 0, and the fields are still reported.
- R11: Any beat or word that matches no form yields `dec_valid` = 1 with `dec_other` = 1 and every other output field and flag 0.
- R12: When a word and a halfword beat arrive in the same cycle, the word's decode is output. The halfword still advances the hold state (captured or released), and its own decode is dropped.
- R13: `dec_valid` is 1 exactly one cycle after a cycle that accepted a word or a decodable halfword beat, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_valid | input | 1 | Halfword beat strobe |
| hw_data | input | 16 | Halfword beat |
| wd_valid | input | 1 | Conditional-form word strobe |
| wd_data | input | 32 | Conditional-form word |
| arch_v6_up | input | 1 | 1 when the core is version 6 or later |
| dec_valid | output | 1 | Decode result present |
| dec_other | output | 1 | Pattern is not this instruction |
| dec_rt | output | 4 | Source data register |
| dec_rn | output | 4 | Base register |
| dec_rm | output | 4 | Offset register |
| dec_index | output | 1 | Offset applied before access |
| dec_add | output | 1 | Offset added (1) or subtracted (0) |
| dec_wback | output | 1 | Base written back |
| dec_sh_type | output | 2 | Offset shift type (00 = LSL) |
| dec_sh_amt | output | 5 | Offset shift amount |
| dec_cond | output | 4 | Condition code (1110 for compact forms) |
| dec_undef | output | 1 | Undefined encoding |
| dec_unpred | output | 1 | Unpredictable encoding |
| dec_redirect | output | 1 | Belongs to the unprivileged variant |

## Verification
The halfword path and the word path can both complete in one cycle. The richest case is a word arriving on the very beat that finishes a held 32-bit compact pair. The bench forces such collisions in directed steps. Random stimulus, which raises both strobes independently, produces many more. A collision is judged by requiring the word's decode at the output. The following halfword beat must also decode as if the colliding beat had released or captured the hold exactly as it would alone.

// File: rtl/sb_dec_pkg.sv
// Shared widths, constants and the decoded-result record for the store-byte
// register-offset decoder. Assumes the fixed instruction field widths.
package sb_dec_pkg;
    localparam int HW_W   = 16;
    localparam int WD_W   = 32;
    localparam int RIDX_W = 4;
    localparam int AMT_W  = 5;
    localparam int TYP_W  = 2;
    localparam int COND_W = 4;

    localparam logic [COND_W-1:0] COND_ALWAYS = 4'b1110;
    localparam logic [TYP_W-1:0]  SHIFT_LSL   = 2'b00;

    typedef struct packed {
        logic              other;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rn;
        logic [RIDX_W-1:0] rm;
        logic              index;
        logic              add;
        logic              wback;
        logic [TYP_W-1:0]  sh_type;
        logic [AMT_W-1:0]  sh_amt;
        logic [COND_W-1:0] cond;
        logic              undef;
        logic              unpred;
        logic              redirect;
    } dec_t;

    localparam dec_t DEC_NONE = '{other: 1'b1, default: '0};
endpackage

// File: rtl/sb_hw_assembler.sv
// Halfword assembler: splits the halfword stream into single 16-bit
// instructions and two-beat 32-bit instructions. A first halfword whose top
// five bits are 11101/11110/11111 is held until the next valid beat.
// Outputs are combinational from the current beat and the held state.
module sb_hw_assembler
    import sb_dec_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hw_valid,
    input  logic [HW_W-1:0] hw_data,
    output logic            narrow_vld,
    output logic [HW_W-1:0] narrow_hw,
    output logic            wide_vld,
    output logic [HW_W-1:0] wide_hi,
    output logic [HW_W-1:0] wide_lo
);
    logic            pending_q;
    logic [HW_W-1:0] hi_q;
    logic            is_lead;

    // Leading-halfword test on the top five bits.
    always_comb begin
        is_lead = (hw_data[HW_W-1 -: 3] == 3'b111) && (hw_data[HW_W-4 -: 2] != 2'b00);
    end

    // Route the current beat to the narrow or wide output.
    always_comb begin
        narrow_vld = hw_valid && !pending_q && !is_lead;
        narrow_hw  = hw_data;
        wide_vld   = hw_valid && pending_q;
        wide_hi    = hi_q;
        wide_lo    = hw_data;
    end

    // Hold state: capture a leading halfword, release on the next beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            hi_q      <= '0;
        end else if (hw_valid) begin
            if (pending_q) begin
                pending_q <= 1'b0;
            end else if (is_lead) begin
                pending_q <= 1'b1;
                hi_q      <= hw_data;
            end
        end
    end

    // R3
    hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && !hw_valid) |=> (pending_q && $stable(hi_q)));

    // R3
    wide_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wide_vld |=> !pending_q);
endmodule

// File: rtl/sb_dec_t16.sv
// 16-bit compact form decoder (combinational). Assumes one halfword that is
// not part of a 32-bit pair. Fixed pre-index, add, no writeback, LSL #0.
module sb_dec_t16
    import sb_dec_pkg::*;
(
    input  logic [HW_W-1:0] hw,
    output dec_t            dec
);
    localparam int LOW_W = 3;

    // Match the opcode bits and extract the 3-bit register fields.
    always_comb begin
        dec = DEC_NONE;
        if (hw[15:9] == 7'b0101010) begin
            dec         = '0;
            dec.rm      = RIDX_W'(hw[8:6]);
            dec.rn      = RIDX_W'(hw[5:3]);
            dec.rt      = RIDX_W'(hw[LOW_W-1:0]);
            dec.index   = 1'b1;
            dec.add     = 1'b1;
            dec.wback   = 1'b0;
            dec.sh_type = SHIFT_LSL;
            dec.sh_amt  = '0;
            dec.cond    = COND_ALWAYS;
        end
    end
endmodule

// File: rtl/sb_dec_t32.sv
// 32-bit compact form decoder (combinational). Assumes the two halfwords
// were already paired by the assembler. Reports undefined for base 15 and
// unpredictable for data or offset register 13 or 15.
module sb_dec_t32
    import sb_dec_pkg::*;
(
    input  logic [HW_W-1:0] hi,
    input  logic [HW_W-1:0] lo,
    output dec_t            dec
);
    logic [RIDX_W-1:0] r_t, r_m;

    // Flags a register index the wide compact form does not allow.
    function automatic logic bad_idx(input logic [RIDX_W-1:0] r);
        return (r == 4'd13) || (r == 4'd15);
    endfunction

    // Extract the data and offset register indices.
    always_comb begin
        r_t = lo[15:12];
        r_m = lo[3:0];
    end

    // Match fixed bits, extract fields and evaluate the error rules.
    always_comb begin
        dec = DEC_NONE;
        if ((hi[15:4] == 12'hF80) && (lo[11:6] == 6'd0)) begin
            dec         = '0;
            dec.rn      = hi[3:0];
            dec.rt      = r_t;
            dec.rm      = r_m;
            dec.index   = 1'b1;
            dec.add     = 1'b1;
            dec.wback   = 1'b0;
            dec.sh_type = SHIFT_LSL;
            dec.sh_amt  = AMT_W'(lo[5:4]);
            dec.cond    = COND_ALWAYS;
            dec.undef   = (hi[3:0] == 4'hF);
            dec.unpred  = bad_idx(r_t) || bad_idx(r_m);
        end
    end
endmodule

// File: rtl/sb_dec_a32.sv
// Conditional 32-bit form decoder (combinational). Shift type and amount are
// passed raw for a downstream shifter. P=0 with W=1 is redirected to the
// unprivileged variant and then carries no error flags.
module sb_dec_a32
    import sb_dec_pkg::*;
(
    input  logic [WD_W-1:0] wd,
    input  logic            v6_up,
    output dec_t            dec
);
    logic p_bit, u_bit, w_bit, wb, match;
    logic [RIDX_W-1:0] r_n, r_t, r_m;

    // Field split and fixed-bit match.
    always_comb begin
        p_bit = wd[24];
        u_bit = wd[23];
        w_bit = wd[21];
        r_n   = wd[19:16];
        r_t   = wd[15:12];
        r_m   = wd[3:0];
        wb    = !p_bit || w_bit;
        match = (wd[27:25] == 3'b011) && wd[22] && !wd[20] && !wd[4];
    end

    // Build the result and apply the redirect and unpredictable rules.
    always_comb begin
        dec = DEC_NONE;
        if (match) begin
            dec         = '0;
            dec.cond    = wd[31:28];
            dec.rn      = r_n;
            dec.rt      = r_t;
            dec.rm      = r_m;
            dec.index   = p_bit;
            dec.add     = u_bit;
            dec.wback   = wb;
            dec.sh_type = wd[6:5];
            dec.sh_amt  = wd[11:7];
            if (!p_bit && w_bit) begin
                dec.redirect = 1'b1;
            end else begin
                dec.unpred = (r_t == 4'hF) || (r_m == 4'hF)
                          || (wb && ((r_n == 4'hF) || (r_n == r_t)))
                          || (!v6_up && wb && (r_m == r_n));
            end
        end
    end
endmodule

// File: rtl/sb_regoff_decoder.sv
// Top: store-byte register-offset decoder. Pairs halfwords, decodes all
// three forms and registers one result per cycle. The word input wins over a
// halfword result in the same cycle; the halfword still advances the pairing.
module sb_regoff_decoder
    import sb_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_valid,
    input  logic [HW_W-1:0]   hw_data,
    input  logic              wd_valid,
    input  logic [WD_W-1:0]   wd_data,
    input  logic              arch_v6_up,
    output logic              dec_valid,
    output logic              dec_other,
    output logic [RIDX_W-1:0] dec_rt,
    output logic [RIDX_W-1:0] dec_rn,
    output logic [RIDX_W-1:0] dec_rm,
    output logic              dec_index,
    output logic              dec_add,
    output logic              dec_wback,
    output logic [TYP_W-1:0]  dec_sh_type,
    output logic [AMT_W-1:0]  dec_sh_amt,
    output logic [COND_W-1:0] dec_cond,
    output logic              dec_undef,
    output logic              dec_unpred,
    output logic              dec_redirect
);
    logic            narrow_vld, wide_vld;
    logic [HW_W-1:0] narrow_hw, wide_hi, wide_lo;
    dec_t            d16, d32, dwd, next_d, res_q;
    logic            any_vld;
    logic            vld_q;

    sb_hw_assembler u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_valid   (hw_valid),
        .hw_data    (hw_data),
        .narrow_vld (narrow_vld),
        .narrow_hw  (narrow_hw),
        .wide_vld   (wide_vld),
        .wide_hi    (wide_hi),
        .wide_lo    (wide_lo)
    );

    sb_dec_t16 u_t16 (.hw(narrow_hw), .dec(d16));
    sb_dec_t32 u_t32 (.hi(wide_hi), .lo(wide_lo), .dec(d32));
    sb_dec_a32 u_a32 (.wd(wd_data), .v6_up(arch_v6_up), .dec(dwd));

    // Select the result for this cycle: word first, then halfword paths.
    always_comb begin
        any_vld = wd_valid || narrow_vld || wide_vld;
        if (wd_valid)        next_d = dwd;
        else if (wide_vld)   next_d = d32;
        else                 next_d = d16;
    end

    // Output register: one cycle of latency, valid only after a decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= any_vld;
            if (any_vld) res_q <= next_d;
        end
    end

    // Drive the flat output ports from the registered record.
    always_comb begin
        dec_valid    = vld_q;
        dec_other    = res_q.other;
        dec_rt       = res_q.rt;
        dec_rn       = res_q.rn;
        dec_rm       = res_q.rm;
        dec_index    = res_q.index;
        dec_add      = res_q.add;
        dec_wback    = res_q.wback;
        dec_sh_type  = res_q.sh_type;
        dec_sh_amt   = res_q.sh_amt;
        dec_cond     = res_q.cond;
        dec_undef    = res_q.undef;
        dec_unpred   = res_q.unpred;
        dec_redirect = res_q.redirect;
    end

    // R13
    valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(wd_valid || hw_valid));

    // R10
    redirect_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_redirect) |-> (!dec_undef && !dec_unpred && !dec_other));

    // R11
    other_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_other) |-> (!dec_undef && !dec_unpred && !dec_redirect
                                      && dec_rt == '0 && dec_rn == '0 && dec_rm == '0));

    // R5
    undef_wide_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_undef) |-> (dec_rn == 4'hF && dec_cond == COND_ALWAYS && !dec_wback));

    // R12
    word_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_valid && hw_valid) |=> dec_valid);
endmodule

// File: tb/sb_regoff_decoder_test.sv
module sb_regoff_decoder_test;
    localparam time CLK_P = 10ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic hw_valid = 1'b0, wd_valid = 1'b0, arch_v6_up = 1'b1;
    logic [15:0] hw_data = '0;
    logic [31:0] wd_data = '0;
    logic dec_valid, dec_other, dec_index, dec_add, dec_wback;
    logic dec_undef, dec_unpred, dec_redirect;
    logic [3:0] dec_rt, dec_rn, dec_rm, dec_cond;
    logic [1:0] dec_sh_type;
    logic [4:0] dec_sh_amt;

    always #(CLK_P/2) clk = ~clk;

    sb_regoff_decoder uut (.*);

    int tests = 0, fails = 0;
    bit done = 0;
    logic pend_m = 0;
    logic [15:0] hi_m = '0;
    logic exp_v = 0;
    logic [29:0] exp_vec = '0;
    string exp_req = "R1";

    function automatic logic [29:0] pk(logic nt, logic [3:0] t, logic [3:0] n, logic [3:0] m,
            logic i, logic a, logic w, logic [1:0] st, logic [4:0] sa, logic [3:0] cd,
            logic ud, logic up, logic rd);
        return {nt, t, n, m, i, a, w, st, sa, cd, ud, up, rd};
    endfunction

    localparam logic [29:0] NONE_V = {1'b1, 29'd0};

    function automatic logic [29:0] exp_t16(logic [15:0] h);
        if (h[15:9] != 7'h2A) return NONE_V;
        return pk(0, {1'b0, h[2:0]}, {1'b0, h[5:3]}, {1'b0, h[8:6]}, 1, 1, 0, 2'b00, 5'd0, 4'hE, 0, 0, 0);
    endfunction

    function automatic logic [29:0] exp_t32(logic [15:0] h, logic [15:0] l);
        logic [3:0] t, n, m;
        if (h[15:4] != 12'hF80 || l[11:6] != 0) return NONE_V;
        n = h[3:0]; t = l[15:12]; m = l[3:0];
        return pk(0, t, n, m, 1, 1, 0, 2'b00, {3'd0, l[5:4]}, 4'hE, n == 15,
                  t == 13 || t == 15 || m == 13 || m == 15, 0);
    endfunction

    function automatic logic [29:0] exp_a32(logic [31:0] w, logic g6);
        logic p, u, wbk, wb, rd, up;
        logic [3:0] t, n, m;
        if (w[27:25] != 3'b011 || !w[22] || w[20] || w[4]) return NONE_V;
        p = w[24]; u = w[23]; wbk = w[21];
        n = w[19:16]; t = w[15:12]; m = w[3:0];
        wb = (p == 0) || (wbk == 1);
        rd = (p == 0) && (wbk == 1);
        up = 0;
        if (!rd) up = t == 15 || m == 15 || (wb && (n == 15 || n == t)) || (!g6 && wb && m == n);
        return pk(0, t, n, m, p, u, wb, w[6:5], w[11:7], w[31:28], 0, up, rd);
    endfunction

    function automatic logic is_lead(logic [15:0] h);
        return h[15:11] == 5'b11101 || h[15:11] == 5'b11110 || h[15:11] == 5'b11111;
    endfunction

    task automatic check();
        logic [29:0] got;
        got = {dec_other, dec_rt, dec_rn, dec_rm, dec_index, dec_add, dec_wback,
               dec_sh_type, dec_sh_amt, dec_cond, dec_undef, dec_unpred, dec_redirect};
        tests++;
        if (dec_valid !== exp_v || (exp_v && got !== exp_vec)) begin
            fails++;
            $display("FAIL %s: valid=%0b vec=%h expected valid=%0b vec=%h",
                     exp_req, dec_valid, got, exp_v, exp_vec);
        end
    endtask

    // One cycle: check previous result, then drive and predict the next.
    task automatic cycle(logic hv, logic [15:0] hd, logic wv, logic [31:0] wd, logic g6, string tag);
        logic [29:0] hres;
        logic hres_v;
        string hreq;
        @(negedge clk);
        check();
        hw_valid = hv; hw_data = hd; wd_valid = wv; wd_data = wd; arch_v6_up = g6;
        hres_v = 0; hres = '0; hreq = "R3";
        if (hv) begin
            if (pend_m) begin
                hres = exp_t32(hi_m, hd); hres_v = 1; pend_m = 0;
                hreq = hres[29] ? "R11" : hres[2] ? "R5" : hres[1] ? "R6" : "R4";
            end else if (is_lead(hd)) begin
                pend_m = 1; hi_m = hd;
            end else begin
                hres = exp_t16(hd); hres_v = 1;
                hreq = hres[29] ? "R11" : "R2";
            end
        end
        if (wv) begin
            exp_v = 1; exp_vec = exp_a32(wd, g6);
            exp_req = exp_vec[29] ? "R11" : exp_vec[0] ? "R10" : exp_vec[1] ? "R8" : "R7";
            if (hv) exp_req = "R12";
        end else begin
            exp_v = hres_v; exp_vec = hres;
            exp_req = hres_v ? hreq : (hv ? "R3" : "R13");
        end
        if (tag != "") exp_req = tag;
    endtask

    task automatic do_reset();
        @(negedge clk);
        check();
        rst_n = 0; hw_valid = 0; wd_valid = 0;
        pend_m = 0; exp_v = 0; exp_req = "R1";
        @(negedge clk);
        @(negedge clk);
        check();  // R1: output valid cleared under reset
        rst_n = 1;
    endtask

    function automatic logic [31:0] mk_a32(logic [3:0] c, logic p, logic u, logic w,
            logic [3:0] n, logic [3:0] t, logic [4:0] i5, logic [1:0] ty, logic [3:0] m);
        return {c, 3'b011, p, u, 1'b1, w, 1'b0, n, t, i5, ty, 1'b0, m};
    endfunction

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        rst_n = 1;
        // R1: reset state, then reset drops a held halfword
        do_reset();
        cycle(1, 16'hF801, 0, '0, 1, "R3");
        do_reset();
        cycle(1, 16'b0101010_011_010_001, 0, '0, 1, "R1");
        // R2: narrow forms
        cycle(1, 16'b0101010_111_000_101, 0, '0, 1, "R2");
        cycle(1, 16'h0000, 0, '0, 1, "R11");
        // R3/R4: wide pair with idle gap
        cycle(1, 16'hF803, 0, '0, 1, "R3");
        cycle(0, '0, 0, '0, 1, "R3");
        cycle(1, 16'h2035, 0, '0, 1, "R4");
        // R5: base 15
        cycle(1, 16'hF80F, 0, '0, 1, "");
        cycle(1, 16'h1002, 0, '0, 1, "R5");
        // R6: rt 13, then rm 15
        cycle(1, 16'hF801, 0, '0, 1, "");
        cycle(1, 16'hD002, 0, '0, 1, "R6");
        cycle(1, 16'hF801, 0, '0, 1, "");
        cycle(1, 16'h200F, 0, '0, 1, "R6");
        // R11: lead then non-matching second halfword, and other lead codes
        cycle(1, 16'hE800, 0, '0, 1, "");
        cycle(1, 16'h0040, 0, '0, 1, "R11");
        // R7: conditional form fields
        cycle(0, '0, 1, mk_a32(4'h3, 1, 0, 0, 4'h2, 4'h5, 5'd17, 2'b10, 4'h7), 1, "R7");
        // R8: t==15, n==t with writeback
        cycle(0, '0, 1, mk_a32(4'hE, 1, 1, 0, 4'h2, 4'hF, 5'd0, 2'b00, 4'h1), 1, "R8");
        cycle(0, '0, 1, mk_a32(4'hE, 1, 1, 1, 4'h4, 4'h4, 5'd0, 2'b00, 4'h1), 1, "R8");
        // R9: m==n with writeback, pre-v6 vs v6
        cycle(0, '0, 1, mk_a32(4'hE, 1, 1, 1, 4'h6, 4'h1, 5'd3, 2'b01, 4'h6), 0, "R9");
        cycle(0, '0, 1, mk_a32(4'hE, 1, 1, 1, 4'h6, 4'h1, 5'd3, 2'b01, 4'h6), 1, "R9");
        // R10: redirect even with bad registers
        cycle(0, '0, 1, mk_a32(4'h1, 0, 1, 1, 4'hF, 4'hF, 5'd2, 2'b11, 4'hF), 1, "R10");
        // R11: word bit 4 set
        cycle(0, '0, 1, mk_a32(4'hE, 1, 1, 0, 4'h1, 4'h2, 5'd0, 2'b00, 4'h3) | 32'h10, 1, "R11");
        // R12: word collides with completing pair, then with a capture
        cycle(1, 16'hF802, 0, '0, 1, "");
        cycle(1, 16'h3010, 1, mk_a32(4'h0, 1, 1, 0, 4'h1, 4'h2, 5'd4, 2'b00, 4'h3), 1, "R12");
        cycle(1, 16'b0101010_001_001_001, 0, '0, 1, "R12");
        cycle(1, 16'hF804, 1, mk_a32(4'h5, 1, 0, 0, 4'h1, 4'h2, 5'd4, 2'b00, 4'h3), 1, "R12");
        cycle(1, 16'h1023, 0, '0, 1, "R12");
        cycle(0, '0, 0, '0, 1, "R13");
        // Random phase
        for (int k = 0; k < 3000; k++) begin
            logic hv, wv, g6;
            logic [15:0] hd;
            logic [31:0] wd;
            int sel;
            hv = ($urandom % 4) != 0;
            wv = ($urandom % 3) == 0;
            g6 = $urandom % 2;
            sel = $urandom % 4;
            hd = $urandom;
            if (pend_m) begin
                if (sel != 0) hd[11:6] = 0;
                if (sel == 1) hd[15:12] = ($urandom % 2) ? 4'hD : 4'hF;
            end else begin
                if (sel == 0) hd[15:9] = 7'h2A;
                else if (sel == 1) hd[15:4] = 12'hF80;
                else if (sel == 2) hd[15:11] = 5'b11101 + 5'($urandom % 3);
            end
            wd = $urandom;
            if (sel != 3) begin
                wd[27:25] = 3'b011; wd[22] = 1; wd[20] = 0; wd[4] = 0;
                if (sel == 2) wd[3:0] = wd[19:16];
            end
            cycle(hv, hd, wv, wd, g6, "");
        end
        cycle(0, '0, 0, '0, 1, "R13");
        @(negedge clk);
        check();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule